// File: doc/BRIEF.md
# Mode-Dependent GPIO Port Controller

This block owns two 8-bit general-purpose I/O ports. Each pin has an output-value bit and a direction bit, and each port has a synchronized input register. A host reaches all of them through a byte-wide register interface: writes take effect on the clock edge and reads are combinational.

A 3-bit host-interface mode input and a one-bit routing control decide which pins the GPIO logic owns. A pin taken by an alternate function is released by the GPIO logic: its output-enable is low, its output value is 0, writes to its register bits are dropped and all of its register bits read as 0. The alternate functions appear only as select outputs. The register interface has no streaming data path, so every pin of the block is a plain control or status signal.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset every output-value and direction bit is 0, so all output enables and pin outputs are low, and every register reads as 0.
- R2: Writing the direction register of a port (offset 1 for port A, offset 5 for port B; bit value 1 means output) sets the output enable of each owned pin on the next clock edge.
- R3: Writing the output register (offset 0 for port A, offset 4 for port B) sets the driven value of each owned pin on the next edge, and the same offset reads the stored value back.
- R4: The input register (offset 2 for port A, offset 6 for port B) returns the pin level through two flip-flops. A level applied before clock edge k can be read after edge k+1.
- R5: Port A is GPIO only in modes 0, 2 and 4 (4 is the serial-peripheral mode). In every other mode value all of its pins are taken and `pa_alt_sel` is high.
- R6: Bits 0 to 5 of port B are GPIO in every mode.
- R7: In mode 2, bit 7 of port B is taken as the write-high strobe input and `pb7_strobe_sel` is high.
- R8: Bit 0 of the control register at offset 7 routes the interrupt to port B bit 6. While it is set, that pin is taken and `pb6_int_sel` is high. While it is clear, the pin is GPIO. The offset reads the bit back in bit 0, and offset 3 reads 0.
- R9: A taken pin has output enable 0 and output value 0, and its register bits read 0.
- R10: A write to a taken pin's register bit is dropped. The bit keeps its earlier value, which appears again once the pin is owned by GPIO once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_mode | input | 3 | Host interface mode: 0 to 3 parallel, 4 serial peripheral |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pa_pin_in | input | 8 | Port A pin levels |
| pa_pin_out | output | 8 | Port A output values |
| pa_pin_oe | output | 8 | Port A output enables (0 means high-Z) |
| pb_pin_in | input | 8 | Port B pin levels |
| pb_pin_out | output | 8 | Port B output values |
| pb_pin_oe | output | 8 | Port B output enables |
| pa_alt_sel | output | 1 | Port A is taken by the host bus |
| pb6_int_sel | output | 1 | Port B bit 6 carries the interrupt |
| pb7_strobe_sel | output | 1 | Port B bit 7 carries the write-high strobe |

## Verification
A stored bit that is wrong shows on the pin outputs or enables in the cycle after the write, as long as the pin is owned. If the pin is taken, the fault stays hidden until the mode returns, and then it shows at once. A fault in the ownership decode shows in the same cycle that the mode or the routing bit changes, on the enables, the select outputs and the readback. A fault in the synchronizer shows as input data arriving one cycle early or late at the input offsets. The reference model in the bench compares every output on every cycle, so each of these faults is reported in the cycle it first appears.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_W    = 8;
  localparam int NUM_PORTS = 2;
  localparam int OFS_W     = 2;
  localparam int ADDR_W    = OFS_W + $clog2(NUM_PORTS);
  localparam int MODE_W    = 3;

  localparam logic [OFS_W-1:0]  OFS_DOUT = 2'd0;
  localparam logic [OFS_W-1:0]  OFS_DIR  = 2'd1;
  localparam logic [OFS_W-1:0]  OFS_DIN  = 2'd2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd7;

  localparam logic [MODE_W-1:0] MODE_PAR0 = 3'd0;
  localparam logic [MODE_W-1:0] MODE_PAR2 = 3'd2;
  localparam logic [MODE_W-1:0] MODE_SPI  = 3'd4;

  localparam int INT_BIT    = 6;
  localparam int STROBE_BIT = 7;
endpackage

// File: rtl/gpio_mode_decode.sv
module gpio_mode_decode
  import gpio_port_pkg::*;
(
  input  logic [MODE_W-1:0] if_mode,
  input  logic              int_route,
  output logic [PORT_W-1:0] own_a,
  output logic [PORT_W-1:0] own_b,
  output logic              alt_a,
  output logic              sel_int,
  output logic              sel_strobe
);
  logic a_gpio;

  always_comb begin
    a_gpio     = (if_mode == MODE_PAR0) || (if_mode == MODE_PAR2) || (if_mode == MODE_SPI);
    sel_strobe = (if_mode == MODE_PAR2);
    sel_int    = int_route;
    alt_a      = !a_gpio;
    own_a      = {PORT_W{a_gpio}};
    own_b      = '1;
    own_b[STROBE_BIT] = !sel_strobe;
    own_b[INT_BIT]    = !sel_int;
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] own,
  input  logic         wr_dout,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_dout,
  output logic [W-1:0] rd_dir,
  output logic [W-1:0] rd_din
);
  logic [W-1:0] dout_q, dir_q, meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      if (wr_dout) dout_q <= (dout_q & ~own) | (wdata & own);
      if (wr_dir)  dir_q  <= (dir_q  & ~own) | (wdata & own);
    end
  end

  always_comb begin
    pin_out = dout_q & own;
    pin_oe  = dir_q  & own;
    rd_dout = dout_q & own;
    rd_dir  = dir_q  & own;
    rd_din  = sync_q & own;
  end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] if_mode,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [PORT_W-1:0] reg_wdata,
  output logic [PORT_W-1:0] reg_rdata,
  input  logic [PORT_W-1:0] pa_pin_in,
  output logic [PORT_W-1:0] pa_pin_out,
  output logic [PORT_W-1:0] pa_pin_oe,
  input  logic [PORT_W-1:0] pb_pin_in,
  output logic [PORT_W-1:0] pb_pin_out,
  output logic [PORT_W-1:0] pb_pin_oe,
  output logic              pa_alt_sel,
  output logic              pb6_int_sel,
  output logic              pb7_strobe_sel
);
  logic              int_route_q;
  logic [PORT_W-1:0] own     [NUM_PORTS];
  logic [PORT_W-1:0] pin_in  [NUM_PORTS];
  logic [PORT_W-1:0] pin_out [NUM_PORTS];
  logic [PORT_W-1:0] pin_oe  [NUM_PORTS];
  logic [PORT_W-1:0] rd_dout [NUM_PORTS];
  logic [PORT_W-1:0] rd_dir  [NUM_PORTS];
  logic [PORT_W-1:0] rd_din  [NUM_PORTS];
  logic [ADDR_W-OFS_W-1:0] sel_port;
  logic [OFS_W-1:0]        sel_ofs;

  assign sel_port = reg_addr[ADDR_W-1:OFS_W];
  assign sel_ofs  = reg_addr[OFS_W-1:0];

  gpio_mode_decode u_decode (
    .if_mode    (if_mode),
    .int_route  (int_route_q),
    .own_a      (own[0]),
    .own_b      (own[1]),
    .alt_a      (pa_alt_sel),
    .sel_int    (pb6_int_sel),
    .sel_strobe (pb7_strobe_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              int_route_q <= 1'b0;
    else if (reg_wr && reg_addr == CTRL_ADDR) int_route_q <= reg_wdata[0];
  end

  assign pin_in[0] = pa_pin_in;
  assign pin_in[1] = pb_pin_in;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_bank
    logic hit;
    assign hit = (sel_port == g) && reg_wr;
    gpio_port_bank #(.W(PORT_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .own     (own[g]),
      .wr_dout (hit && sel_ofs == OFS_DOUT),
      .wr_dir  (hit && sel_ofs == OFS_DIR),
      .wdata   (reg_wdata),
      .pin_in  (pin_in[g]),
      .pin_out (pin_out[g]),
      .pin_oe  (pin_oe[g]),
      .rd_dout (rd_dout[g]),
      .rd_dir  (rd_dir[g]),
      .rd_din  (rd_din[g])
    );
  end

  assign pa_pin_out = pin_out[0];
  assign pa_pin_oe  = pin_oe[0];
  assign pb_pin_out = pin_out[1];
  assign pb_pin_oe  = pin_oe[1];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_ADDR) begin
      reg_rdata[0] = int_route_q;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (sel_port == p) begin
          case (sel_ofs)
            OFS_DOUT: reg_rdata = rd_dout[p];
            OFS_DIR:  reg_rdata = rd_dir[p];
            OFS_DIN:  reg_rdata = rd_din[p];
            default:  reg_rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk
  import gpio_port_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] if_mode,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [PORT_W-1:0] reg_wdata,
  input logic [PORT_W-1:0] reg_rdata,
  input logic [PORT_W-1:0] pa_pin_in,
  input logic [PORT_W-1:0] pa_pin_out,
  input logic [PORT_W-1:0] pa_pin_oe,
  input logic [PORT_W-1:0] pb_pin_in,
  input logic [PORT_W-1:0] pb_pin_out,
  input logic [PORT_W-1:0] pb_pin_oe,
  input logic              pa_alt_sel,
  input logic              pb6_int_sel,
  input logic              pb7_strobe_sel
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd0) |-> (pa_pin_oe == '0 && pb_pin_oe == '0 && pa_pin_out == '0 && pb_pin_out == '0));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd5) |=> (pb_pin_oe[5:0] == $past(reg_wdata[5:0])));

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && reg_addr == 3'd6) |-> (reg_rdata[5:0] == $past(pb_pin_in[5:0], 2)));

  // R5
  pa_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_mode == 3'd1 || if_mode == 3'd3) |-> (pa_alt_sel && pa_pin_oe == '0 && pa_pin_out == '0));

  // R7
  strobe_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_mode == 3'd2) |-> (pb7_strobe_sel && !pb_pin_oe[7] && !pb_pin_out[7]));

  // R8
  int_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb6_int_sel |-> (!pb_pin_oe[6] && !pb_pin_out[6]));

  // R9
  taken_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_alt_sel && reg_addr[2] == 1'b0 && reg_addr[1:0] != 2'd3) |-> (reg_rdata == '0));
endmodule

bind gpio_port_ctl gpio_port_ctl_chk i_chk (.*);

// File: tb/test_gpio_port_ctl.sv
module test_gpio_port_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] if_mode = '0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pa_pin_in = '0, pa_pin_out, pa_pin_oe;
  logic [7:0] pb_pin_in = '0, pb_pin_out, pb_pin_oe;
  logic       pa_alt_sel, pb6_int_sel, pb7_strobe_sel;

  int checks = 0;
  int fails  = 0;

  always #5ns clk = ~clk;

  gpio_port_ctl i_gpio_port_ctl (.*);

  // behavioural reference state
  logic [7:0] m_dout [2];
  logic [7:0] m_dir  [2];
  logic [7:0] m_pipe [2][$];
  logic       m_ctl;

  function automatic logic [7:0] owned(int port, logic [2:0] mode, logic ctl);
    logic [7:0] m;
    if (port == 0) return (mode == 0 || mode == 2 || mode == 4) ? 8'hFF : 8'h00;
    m = 8'hFF;
    if (mode == 2) m[7] = 1'b0;
    if (ctl)       m[6] = 1'b0;
    return m;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 2; p++) begin
      m_dout[p] = '0; m_dir[p] = '0;
      m_pipe[p].delete();
      m_pipe[p].push_back(8'h00); m_pipe[p].push_back(8'h00);
    end
    m_ctl = 1'b0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int p;
      logic [7:0] own;
      p = reg_addr[2];
      own = owned(p, if_mode, m_ctl);
      if (reg_wr) begin
        if (reg_addr == 3'd7) m_ctl = reg_wdata[0];
        else if (reg_addr[1:0] == 2'd0) m_dout[p] = (m_dout[p] & ~own) | (reg_wdata & own);
        else if (reg_addr[1:0] == 2'd1) m_dir[p]  = (m_dir[p]  & ~own) | (reg_wdata & own);
      end
      m_pipe[0].push_back(pa_pin_in); void'(m_pipe[0].pop_front());
      m_pipe[1].push_back(pb_pin_in); void'(m_pipe[1].pop_front());
    end
  end

  task automatic compare(string req);
    logic [7:0] oa, ob, exp_rd;
    logic [47:0] act, exp;
    int p;
    oa = owned(0, if_mode, m_ctl);
    ob = owned(1, if_mode, m_ctl);
    p = reg_addr[2];
    if (reg_addr == 3'd7) exp_rd = {7'b0, m_ctl};
    else case (reg_addr[1:0])
      2'd0: exp_rd = m_dout[p] & owned(p, if_mode, m_ctl);
      2'd1: exp_rd = m_dir[p]  & owned(p, if_mode, m_ctl);
      2'd2: exp_rd = m_pipe[p][0] & owned(p, if_mode, m_ctl);
      default: exp_rd = 8'h00;
    endcase
    exp = {exp_rd, m_dout[0] & oa, m_dir[0] & oa, m_dout[1] & ob, m_dir[1] & ob,
           5'b0, !(if_mode == 0 || if_mode == 2 || if_mode == 4), m_ctl, if_mode == 3'd2};
    act = {reg_rdata, pa_pin_out, pa_pin_oe, pb_pin_out, pb_pin_oe,
           5'b0, pa_alt_sel, pb6_int_sel, pb7_strobe_sel};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (rdata,paout,paoe,pbout,pboe,sel)", req, act, exp);
    end
  endtask

  task automatic step(string req, logic [2:0] mode, logic [2:0] a, logic w,
                      logic [7:0] d, logic [7:0] pa, logic [7:0] pb);
    @(negedge clk);
    if_mode = mode; reg_addr = a; reg_wr = w; reg_wdata = d;
    pa_pin_in = pa; pb_pin_in = pb;
    #1ns compare(req);
  endtask

  initial begin
    #2000000ns;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    step("R1", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) step("R1", 0, 3'(a), 0, 0, 8'h5A, 8'hC3);
    // R3 / R2 on port A in mode 0
    step("R3", 0, 0, 1, 8'hA5, 8'h3C, 8'h00);
    step("R2", 0, 1, 1, 8'hF0, 8'h3C, 8'h00);
    step("R3", 0, 0, 0, 0, 8'h3C, 8'h00);
    step("R2", 0, 1, 0, 0, 8'h3C, 8'h00);
    // R4 input synchronizer
    step("R4", 0, 2, 0, 0, 8'hC1, 8'h2D);
    step("R4", 0, 2, 0, 0, 8'hC1, 8'h2D);
    step("R4", 0, 6, 0, 0, 8'hC1, 8'h2D);
    step("R4", 0, 6, 0, 0, 8'h18, 8'h3F);
    step("R4", 0, 6, 0, 0, 8'h18, 8'h3F);
    // R5 / R9 / R10 port A taken
    step("R5", 1, 0, 1, 8'hFF, 8'h77, 8'h00);
    step("R10", 1, 1, 1, 8'h0F, 8'h77, 8'h00);
    step("R9", 1, 2, 0, 0, 8'h77, 8'h00);
    step("R5", 3, 0, 0, 0, 8'h77, 8'h00);
    step("R5", 6, 1, 0, 0, 8'h77, 8'h00);
    step("R10", 0, 0, 0, 0, 8'h77, 8'h00);
    step("R10", 0, 1, 0, 0, 8'h77, 8'h00);
    step("R5", 4, 0, 1, 8'h96, 8'h00, 8'h00);
    step("R5", 4, 0, 0, 0, 8'h00, 8'h00);
    // R6 / R7 port B in mode 2
    step("R7", 2, 5, 1, 8'hFF, 8'h00, 8'hFF);
    step("R7", 2, 4, 1, 8'hFF, 8'h00, 8'hFF);
    step("R6", 2, 6, 0, 0, 8'h00, 8'hFF);
    step("R6", 2, 6, 0, 0, 8'h00, 8'hFF);
    step("R7", 2, 5, 0, 0, 8'h00, 8'hFF);
    step("R10", 0, 5, 0, 0, 8'h00, 8'hFF);
    step("R7", 0, 6, 0, 0, 8'h00, 8'hFF);
    // R8 interrupt routing
    step("R8", 0, 7, 1, 8'h01, 8'h00, 8'hFF);
    step("R8", 0, 7, 0, 0, 8'h00, 8'hFF);
    step("R8", 0, 5, 1, 8'h00, 8'h00, 8'hFF);
    step("R8", 0, 5, 0, 0, 8'h00, 8'hFF);
    step("R8", 2, 3, 0, 0, 8'h00, 8'hFF);
    step("R8", 0, 7, 1, 8'hFE, 8'h00, 8'hFF);
    step("R10", 0, 5, 0, 0, 8'h00, 8'hFF);
    step("R6", 5, 4, 1, 8'h2A, 8'h00, 8'h15);
    step("R6", 7, 6, 0, 0, 8'h00, 8'h15);
    step("R6", 7, 6, 0, 0, 8'h00, 8'h15);
    // mid-run reset
    @(negedge clk); rst_n = 1'b0;
    step("R1", 0, 4, 0, 0, 0, 0);
    rst_n = 1'b1;
    step("R1", 0, 7, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule